// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is a memory-mapped mailbox that lets a host processor hand a command to an embedded controller and collect the answer. The host loads up to 16 bytes of argument data into an outbound buffer. It then writes a 32-bit command word, and that write is itself the doorbell. The block latches the command, raises busy and pulses a request interrupt toward the controller.

The controller reads the latched command and the outbound bytes through a byte-wide port. It writes response bytes into an inbound buffer, then strobes completion with an error flag and an 8-bit error code. Completion clears busy and records the result in the status word. If the command asked for interrupt-on-completion, completion also fires a single-cycle host interrupt that needs no clearing. Otherwise the host polls busy. The host reads the inbound buffer as 32-bit words or as single bytes.

Host accesses are single-cycle strobes on a plain address/data interface. Read data is combinational and is valid during the cycle in which `host_rd` is high.

Top module: `ipc_mailbox`

## Requirements
- R1: A host write to offset 0x00 while busy is clear latches the full 32-bit command onto `ctl_cmd` and sets busy on the next clock edge. The command holds opcode [7:0], interrupt-on-completion [8], sub-command id [15:12] and data size [23:16]. The same write clears the stored error flag and error code.
- R2: `ctl_req_irq` is high for exactly the one cycle that follows the edge at which a command was accepted.
- R3: A command write while busy is set is ignored. `ctl_cmd`, busy and the reported sub-command id keep their values, and no request pulse is produced.
- R4: A read of offset 0x04 returns the status word. Busy is at bit 0 and error at bit 1. The sub-command id of the last accepted command is at [7:4], the `INIT_ID` parameter is at [15:8] and the error code is at [23:16]. All other bits read 0.
- R5: A `ctl_done` strobe while busy clears busy and stores `ctl_err` and `ctl_err_code` at the same edge. A strobe while busy is clear changes nothing.
- R6: `host_irq` pulses for one cycle after a completion, and only when bit 8 of the completed command was 1.
- R7: Host word writes to 0x80 + 4k fill outbound bytes 4k to 4k+3 in little-endian order (wdata[7:0] goes to byte 4k). The controller reads byte i on `ctl_wb_data` by placing i on `ctl_wb_idx`.
- R8: The controller writes inbound byte i through `ctl_rb_we`/`ctl_rb_idx`/`ctl_rb_wdata`. A host read of 0x90 + 4k with `host_byte`=0 returns bytes 4k..4k+3 in little-endian order. With `host_byte`=1, the read returns byte `host_addr`[3:0] zero-extended to 32 bits.
- R9: The command register and the outbound buffer read back as 0. Host writes to the status word and to the inbound buffer have no effect.
- R10: After reset, busy and error are 0, both buffers hold 0, the sub-command id and error code are 0, and neither interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; read data is 0 when low |
| host_byte | input | 1 | Byte-sized read of the inbound buffer |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| host_irq | output | 1 | Completion interrupt pulse |
| ctl_req_irq | output | 1 | Request interrupt pulse to the controller |
| ctl_cmd | output | 32 | Latched command word |
| ctl_wb_idx | input | IDX_W | Outbound byte index |
| ctl_wb_data | output | 8 | Outbound byte at `ctl_wb_idx` |
| ctl_rb_we | input | 1 | Inbound byte write enable |
| ctl_rb_idx | input | IDX_W | Inbound byte index |
| ctl_rb_wdata | input | 8 | Inbound byte data |
| ctl_done | input | 1 | Completion strobe |
| ctl_err | input | 1 | Error flag sampled with `ctl_done` |
| ctl_err_code | input | 8 | Error code sampled with `ctl_done` |

## Verification
The embedded properties assume that `ctl_done` is a single-cycle strobe and that the controller raises it only after it has seen the request. They also assume the host never asserts `host_wr` and `host_rd` together. The stimulus drives every strobe for exactly one cycle from the falling edge and never overlaps host reads with writes. It deliberately issues one completion strobe while idle and one command write while busy, so that the ignore paths are exercised without breaking those assumptions.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;

   // Host-visible byte offsets
   localparam int CMD_OFF  = 'h00;
   localparam int STAT_OFF = 'h04;
   localparam int WB_BASE  = 'h80;
   localparam int RB_BASE  = 'h90;

   // Command word; field positions are decoded by the controller
   typedef struct packed {
      logic [7:0] rsv_hi;
      logic [7:0] size;
      logic [3:0] sub_id;
      logic [2:0] rsv_lo;
      logic       ioc;
      logic [7:0] opcode;
   } ipcmb_cmd_t;

   function automatic logic [31:0] pack_status(
      input logic       busy,
      input logic       err,
      input logic [3:0] sub_id,
      input logic [7:0] init_id,
      input logic [7:0] code);
      return {8'h00, code, init_id, sub_id, 2'b00, err, busy};
   endfunction

endpackage

// File: rtl/ipcmb_bytebuf.sv
module ipcmb_bytebuf #(
   parameter int BYTES      = 16,
   parameter int WORD_BYTES = 4,
   localparam int IDX_W  = $clog2(BYTES),
   localparam int WORDS  = BYTES / WORD_BYTES,
   localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int WORD_W = 8 * WORD_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_we,
   input  logic [WIDX_W-1:0] word_idx,
   input  logic [WORD_W-1:0] word_wdata,
   input  logic              byte_we,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [7:0]        byte_wdata,
   input  logic [IDX_W-1:0]  rd_byte_idx,
   output logic [7:0]        rd_byte,
   input  logic [WIDX_W-1:0] rd_word_idx,
   output logic [WORD_W-1:0] rd_word
);

   if (BYTES % WORD_BYTES != 0) begin : g_bad_geom
      $error("ipcmb_bytebuf: BYTES must be a multiple of WORD_BYTES");
   end

   logic [8*BYTES-1:0] flat;

   for (genvar g = 0; g < BYTES; g++) begin : g_cell
      logic [7:0] cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cell_q <= '0;
         end else if (word_we && (word_idx == WIDX_W'(g / WORD_BYTES))) begin
            cell_q <= word_wdata[(g % WORD_BYTES)*8 +: 8];
         end else if (byte_we && (byte_idx == IDX_W'(g))) begin
            cell_q <= byte_wdata;
         end
      end
      assign flat[g*8 +: 8] = cell_q;
   end

   always_comb begin
      rd_byte = flat[rd_byte_idx*8 +: 8];
   end

   for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
      always_comb begin
         rd_word[b*8 +: 8] = flat[(int'(rd_word_idx)*WORD_BYTES + b)*8 +: 8];
      end
   end

endmodule

// File: rtl/ipcmb_ctrl.sv
module ipcmb_ctrl
   import ipcmb_pkg::*;
#(
   parameter logic [7:0] INIT_ID = 8'h5A
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_wr,
   input  logic [31:0] cmd_wdata,
   input  logic        done,
   input  logic        done_err,
   input  logic [7:0]  done_code,
   output logic        busy,
   output ipcmb_cmd_t  cmd_q,
   output logic [31:0] status,
   output logic        req_irq,
   output logic        host_irq
);

   logic       err_q;
   logic [7:0] code_q;
   logic       accept;
   logic       finish;

   assign accept = cmd_wr && !busy;
   assign finish = done && busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cmd_q    <= '0;
         err_q    <= 1'b0;
         code_q   <= '0;
         req_irq  <= 1'b0;
         host_irq <= 1'b0;
      end else begin
         req_irq  <= accept;
         host_irq <= finish && cmd_q.ioc;
         if (accept) begin
            busy   <= 1'b1;
            cmd_q  <= ipcmb_cmd_t'(cmd_wdata);
            err_q  <= 1'b0;
            code_q <= '0;
         end else if (finish) begin
            busy   <= 1'b0;
            err_q  <= done_err;
            code_q <= done_code;
         end
      end
   end

   assign status = pack_status(busy, err_q, cmd_q.sub_id, INIT_ID, code_q);

   // R2
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_irq |-> $rose(busy));

   // R2
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_irq |=> !req_irq);

   // R3
   busy_cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_wr && !done) |=> (busy && $stable(cmd_q)));

   // R5
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && done) |=> !busy);

   // R6
   irq_on_ioc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> ($fell(busy) && cmd_q.ioc));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
   import ipcmb_pkg::*;
#(
   parameter int         ADDR_W    = 8,
   parameter int         BUF_BYTES = 16,
   parameter logic [7:0] INIT_ID   = 8'h5A,
   localparam int IDX_W  = $clog2(BUF_BYTES),
   localparam int WIDX_W = IDX_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic              host_byte,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              host_irq,
   output logic              ctl_req_irq,
   output logic [31:0]       ctl_cmd,
   input  logic [IDX_W-1:0]  ctl_wb_idx,
   output logic [7:0]        ctl_wb_data,
   input  logic              ctl_rb_we,
   input  logic [IDX_W-1:0]  ctl_rb_idx,
   input  logic [7:0]        ctl_rb_wdata,
   input  logic              ctl_done,
   input  logic              ctl_err,
   input  logic [7:0]        ctl_err_code
);

   localparam int TAG_W = ADDR_W - IDX_W;

   if (BUF_BYTES < 8 || BUF_BYTES > 16 || (BUF_BYTES % 4) != 0) begin : g_bad_buf
      $error("ipc_mailbox: BUF_BYTES must be 8, 12 or 16");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ipc_mailbox: ADDR_W must reach the buffer offsets");
   end

   // Address decode
   logic              hit_cmd, hit_stat, hit_wb, hit_rb;
   logic [IDX_W-1:0]  byte_off;
   logic [WIDX_W-1:0] word_off;

   assign hit_cmd  = (host_addr == ADDR_W'(CMD_OFF));
   assign hit_stat = (host_addr == ADDR_W'(STAT_OFF));
   assign hit_wb   = (host_addr[ADDR_W-1:IDX_W] == TAG_W'(WB_BASE >> IDX_W));
   assign hit_rb   = (host_addr[ADDR_W-1:IDX_W] == TAG_W'(RB_BASE >> IDX_W));
   assign byte_off = host_addr[IDX_W-1:0];
   assign word_off = host_addr[IDX_W-1:2];

   // Command and status sequencing
   ipcmb_cmd_t  cmd_q;
   logic        busy;
   logic [31:0] status;

   ipcmb_ctrl #(.INIT_ID(INIT_ID)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (host_wr && hit_cmd),
      .cmd_wdata (host_wdata),
      .done      (ctl_done),
      .done_err  (ctl_err),
      .done_code (ctl_err_code),
      .busy      (busy),
      .cmd_q     (cmd_q),
      .status    (status),
      .req_irq   (ctl_req_irq),
      .host_irq  (host_irq)
   );

   assign ctl_cmd = cmd_q;

   // Outbound buffer: host words in, controller bytes out
   logic [31:0] wb_word_unused;

   ipcmb_bytebuf #(.BYTES(BUF_BYTES), .WORD_BYTES(4)) u_wbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_we     (host_wr && hit_wb),
      .word_idx    (word_off),
      .word_wdata  (host_wdata),
      .byte_we     (1'b0),
      .byte_idx    ('0),
      .byte_wdata  (8'h00),
      .rd_byte_idx (ctl_wb_idx),
      .rd_byte     (ctl_wb_data),
      .rd_word_idx ('0),
      .rd_word     (wb_word_unused)
   );

   // Inbound buffer: controller bytes in, host words or bytes out
   logic [7:0]  rb_byte;
   logic [31:0] rb_word;

   ipcmb_bytebuf #(.BYTES(BUF_BYTES), .WORD_BYTES(4)) u_rbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .word_we     (1'b0),
      .word_idx    ('0),
      .word_wdata  (32'h0),
      .byte_we     (ctl_rb_we),
      .byte_idx    (ctl_rb_idx),
      .byte_wdata  (ctl_rb_wdata),
      .rd_byte_idx (byte_off),
      .rd_byte     (rb_byte),
      .rd_word_idx (word_off),
      .rd_word     (rb_word)
   );

   // Host read mux
   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         if (hit_stat) begin
            host_rdata = status;
         end else if (hit_rb) begin
            host_rdata = host_byte ? {24'h0, rb_byte} : rb_word;
         end
      end
   end

   // R4
   stat_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && hit_stat) |-> (host_rdata[0] == busy && host_rdata[15:8] == INIT_ID));

   // R9
   wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && (hit_cmd || hit_wb)) |-> (host_rdata == 32'h0));

endmodule

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;

   localparam int IDX_W = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0, host_byte = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_irq, ctl_req_irq;
   logic [31:0] ctl_cmd;
   logic [IDX_W-1:0] ctl_wb_idx = '0;
   logic [7:0]  ctl_wb_data;
   logic        ctl_rb_we = 1'b0;
   logic [IDX_W-1:0] ctl_rb_idx = '0;
   logic [7:0]  ctl_rb_wdata = '0;
   logic        ctl_done = 1'b0, ctl_err = 1'b0;
   logic [7:0]  ctl_err_code = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [31:0] exp_q[$];
   string       req_q[$];

   always #2 clk = ~clk;

   ipc_mailbox dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_byte(host_byte), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_irq(host_irq), .ctl_req_irq(ctl_req_irq),
      .ctl_cmd(ctl_cmd), .ctl_wb_idx(ctl_wb_idx), .ctl_wb_data(ctl_wb_data),
      .ctl_rb_we(ctl_rb_we), .ctl_rb_idx(ctl_rb_idx), .ctl_rb_wdata(ctl_rb_wdata),
      .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_err_code(ctl_err_code)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Monitor: pops expected read data while a host read is active
   always @(negedge clk) begin
      #1;
      if (host_rd) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard-empty", host_rdata, 32'h0);
         end else begin
            logic [31:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(host_rdata == e, r, host_rdata, e);
         end
      end
   end

   task automatic host_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [7:0] a, input bit by,
                            input logic [31:0] e, input string r);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a; host_byte = by;
      exp_q.push_back(e);
      req_q.push_back(r);
      @(negedge clk);
      host_rd = 1'b0; host_byte = 1'b0;
   endtask

   task automatic ctl_complete(input bit er, input logic [7:0] code);
      @(negedge clk);
      ctl_done = 1'b1; ctl_err = er; ctl_err_code = code;
      @(negedge clk);
      ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0;
   endtask

   task automatic ctl_put(input logic [3:0] i, input logic [7:0] d);
      @(negedge clk);
      ctl_rb_we = 1'b1; ctl_rb_idx = i; ctl_rb_wdata = d;
      @(negedge clk);
      ctl_rb_we = 1'b0;
   endtask

   task automatic wb_peek(input logic [3:0] i, input logic [7:0] e);
      ctl_wb_idx = i;
      #1;
      check(ctl_wb_data == e, "R7 outbound byte", {24'h0, ctl_wb_data}, {24'h0, e});
   endtask

   task automatic irq_now(input bit req_e, input bit host_e, input string r);
      #1;
      check(ctl_req_irq == req_e, r, {31'h0, ctl_req_irq}, {31'h0, req_e});
      check(host_irq == host_e, r, {31'h0, host_irq}, {31'h0, host_e});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      host_read(8'h04, 1'b0, 32'h0000_5A00, "R10 status after reset");
      host_read(8'h90, 1'b0, 32'h0, "R10 inbound buffer after reset");
      wb_peek(4'd5, 8'h00);
      irq_now(1'b0, 1'b0, "R10 irqs after reset");

      // R7 outbound buffer, R9 write-only reads
      host_write(8'h80, 32'h4433_2211);
      host_write(8'h8C, 32'hDDCC_BBAA);
      wb_peek(4'd0, 8'h11);
      wb_peek(4'd3, 8'h44);
      wb_peek(4'd12, 8'hAA);
      wb_peek(4'd15, 8'hDD);
      host_read(8'h80, 1'b0, 32'h0, "R9 outbound reads zero");

      // R1 R2 command accepted
      host_write(8'h00, 32'h0008_30FF);
      irq_now(1'b1, 1'b0, "R2 request pulse");
      check(ctl_cmd == 32'h0008_30FF, "R1 latched command", ctl_cmd, 32'h0008_30FF);
      @(negedge clk);
      irq_now(1'b0, 1'b0, "R2 request single cycle");
      host_read(8'h04, 1'b0, 32'h0000_5A31, "R4 status busy with sub id");

      // R3 write while busy
      host_write(8'h00, 32'h0000_5101);
      irq_now(1'b0, 1'b0, "R3 no request while busy");
      check(ctl_cmd == 32'h0008_30FF, "R3 command kept", ctl_cmd, 32'h0008_30FF);
      host_read(8'h04, 1'b0, 32'h0000_5A31, "R3 status unchanged");

      // R8 controller fills response, R5 completion without error
      for (int i = 0; i < 8; i++) ctl_put(4'(i), 8'hA0 + 8'(i));
      ctl_complete(1'b0, 8'h00);
      irq_now(1'b0, 1'b0, "R6 no host irq without ioc");
      host_read(8'h04, 1'b0, 32'h0000_5A30, "R5 busy cleared");
      host_read(8'h90, 1'b0, 32'hA3A2_A1A0, "R8 inbound word 0");
      host_read(8'h94, 1'b0, 32'hA7A6_A5A4, "R8 inbound word 1");
      host_read(8'h95, 1'b1, 32'h0000_00A5, "R8 inbound byte 5");
      host_read(8'h9F, 1'b1, 32'h0000_0000, "R8 inbound byte 15");

      // R9 writes to read-only locations
      host_write(8'h90, 32'hFFFF_FFFF);
      host_write(8'h04, 32'hFFFF_FFFF);
      host_read(8'h90, 1'b0, 32'hA3A2_A1A0, "R9 inbound unchanged by host write");
      host_read(8'h04, 1'b0, 32'h0000_5A30, "R9 status unchanged by host write");

      // R6 interrupt-on-completion with error
      host_write(8'h00, 32'h0004_7102);
      irq_now(1'b1, 1'b0, "R2 request pulse ioc command");
      host_read(8'h04, 1'b0, 32'h0000_5A71, "R4 status ioc command busy");
      ctl_complete(1'b1, 8'h3C);
      irq_now(1'b0, 1'b1, "R6 host irq pulse");
      @(negedge clk);
      irq_now(1'b0, 1'b0, "R6 host irq single cycle");
      host_read(8'h04, 1'b0, 32'h003C_5A72, "R5 error and code stored");

      // R5 completion while idle ignored
      ctl_complete(1'b0, 8'h11);
      irq_now(1'b0, 1'b0, "R5 idle strobe no irq");
      host_read(8'h04, 1'b0, 32'h003C_5A72, "R5 idle strobe ignored");

      // R1 new command clears error
      host_write(8'h00, 32'h0000_2005);
      host_read(8'h04, 1'b0, 32'h0000_5A21, "R1 error cleared on accept");
      ctl_complete(1'b0, 8'h00);
      host_read(8'h04, 1'b0, 32'h0000_5A20, "R5 second completion");
      host_read(8'h00, 1'b0, 32'h0, "R9 command reads zero");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) check(1'b0, "scoreboard-leftover", 32'(exp_q.size()), 32'h0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", 32'h0, 32'h1);
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule